// File: doc/BRIEF.md
# Two-Bit Serial APP Update Lane

This lane refreshes one 6-bit two's-complement a-posteriori log-likelihood value for a layered min-sum decoder. Each value moves through the lane as three 2-bit pairs, least significant pair first, over three consecutive controller states (index 0, 1 and 2). While the pairs of a new message come in, the lane subtracts the old check message from them and assembles a variable-node value. At the same time it adds the fresh check message to the variable-node value completed in the previous slot, and sends the result out two bits per state. Check messages arrive as a sign bit plus a 4-bit magnitude. A sign-controlled inversion lets one small ripple adder either add or subtract, so no two's-complement conversion is needed.

Overflow of the outgoing sum is predicted in state 1, before the most significant pair is sent. This means the serial link never needs a third wire to signal a late overflow. The low pair already sent is not corrected, so a saturated result can be up to 3 ulp below the true limit. A per-message enable chooses between updating the value and passing it through unchanged. The enable and both check messages are captured in state 0 and held for the whole message.

Top module: `app_serial_lane`

## Requirements
- R1: In state index 0, 1 and 2 the lane carries bits [1:0], [3:2] and [5:4] respectively. Each output pair appears one clock after the input state that produced it, and `outIdx` repeats that state index.
- R2: For an enabled message whose sum does not leave [-32, +31], the output value equals the stored variable-node value plus the new check message. The new check message is -mag when `newSign` is 1 and +mag when it is 0.
- R3: The stored variable-node value equals the incoming APP value minus the old check message (same sign coding), clamped to [-32, +31].
- R4: If the enabled sum exceeds +31, the output pair for state 1 is 11, the pair for state 2 is 01, and the pair for state 0 carries the low two bits of the exact sum.
- R5: If the enabled sum falls below -32, the output pair for state 1 is 00, the pair for state 2 is 10, and the pair for state 0 carries the low two bits of the exact sum.
- R6: A message driven with `updEn` at 0 leaves the lane unchanged. Neither check message affects it.
- R7: `outValid` is high for a state only when a completed message was held at that state's input edge. It stays low during the first slot after reset and in every cycle that follows a cycle with `inValid` low. A held message survives idle cycles.
- R8: While `rstN` is low, `outValid` and `outPair` are 0.
- R9: The enable, the check signs and the check magnitudes are taken in state 0. Values driven on them in states 1 and 2 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| stateIdx | input | 2 | Controller state index 0, 1 or 2 |
| inValid | input | 1 | A state is presented this cycle |
| updEn | input | 1 | 1 updates the message, 0 passes it through (taken in state 0) |
| appPair | input | 2 | Incoming APP bit pair for the current state |
| oldSign | input | 1 | Sign of the check message to remove (1 = negative) |
| oldMag | input | 4 | Magnitude of the check message to remove |
| newSign | input | 1 | Sign of the check message to add (1 = negative) |
| newMag | input | 4 | Magnitude of the check message to add |
| outPair | output | 2 | Updated APP bit pair |
| outValid | output | 1 | outPair carries a result |
| outIdx | output | 2 | State index the outPair belongs to |

## Verification
The bench uses the default parameters: 2-bit pairs, three states and a 4-bit magnitude. With these values every incoming APP value meets every signed old check message, including negative zero, across 2048 back-to-back messages. The new check messages, enables and state-1/state-2 disturbances follow co-prime patterns. This drives the sums past both limits and across both pre-update clamps.

// File: rtl/lane_pkg.sv
`timescale 1ns/1ps
package lane_pkg;
  localparam int PAIR_W = 2;
  localparam int NUM_ST = 3;
  localparam int MAG_W  = 4;
  localparam int MSG_W  = PAIR_W * NUM_ST;
  localparam int IDX_W  = $clog2(NUM_ST);

  typedef struct packed {
    logic             vld;
    logic             s0;
    logic             s1;
    logic             s2;
    logic [IDX_W-1:0] idx;
    logic             en;
    logic             preInv;
    logic             postInv;
  } laneStrobe_t;
endpackage

// File: rtl/lane_ctrl.sv
`timescale 1ns/1ps
module lane_ctrl
  import lane_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] stateIdx,
  input  logic             inValid,
  input  logic             updEn,
  input  logic             oldSign,
  input  logic             newSign,
  output laneStrobe_t      stb
);
  logic enQ, preInvQ, postInvQ;
  logic isS0;

  assign isS0 = (stateIdx == IDX_W'(0));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ      <= 1'b0;
      preInvQ  <= 1'b0;
      postInvQ <= 1'b0;
    end else if (inValid && isS0) begin
      enQ      <= updEn;
      preInvQ  <= ~oldSign;
      postInvQ <= newSign;
    end
  end

  always_comb begin
    stb.vld     = inValid;
    stb.s0      = isS0;
    stb.s1      = (stateIdx == IDX_W'(1));
    stb.s2      = (stateIdx == IDX_W'(NUM_ST - 1));
    stb.idx     = stateIdx;
    stb.en      = isS0 ? updEn    : enQ;
    stb.preInv  = isS0 ? ~oldSign : preInvQ;
    stb.postInv = isS0 ? newSign  : postInvQ;
  end

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> (stateIdx < IDX_W'(NUM_ST))); // R1
  AST_S1_AFTER_S0: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && stateIdx == IDX_W'(1)) |-> $past(inValid && stateIdx == IDX_W'(0))); // R1
endmodule

// File: rtl/lane_datapath.sv
`timescale 1ns/1ps
module lane_datapath
  import lane_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  laneStrobe_t       stb,
  input  logic [PAIR_W-1:0] appPair,
  input  logic [MAG_W-1:0]  oldMag,
  input  logic [MAG_W-1:0]  newMag,
  output logic [PAIR_W-1:0] outPair,
  output logic              outValid,
  output logic [IDX_W-1:0]  outIdx
);
  localparam int ACC_W = MSG_W - PAIR_W;

  // ripple add of one pair: {carry out, carry into top bit, sum}
  function automatic logic [PAIR_W+1:0] ripPair(input logic [PAIR_W-1:0] a,
                                                input logic [PAIR_W-1:0] b,
                                                input logic cin);
    logic [PAIR_W-1:0] s;
    logic c, cTop;
    c = cin;
    cTop = cin;
    for (int i = 0; i < PAIR_W; i++) begin
      if (i == PAIR_W - 1) cTop = c;
      s[i] = a[i] ^ b[i] ^ c;
      c    = (a[i] & b[i]) | (a[i] & c) | (b[i] & c);
    end
    return {c, cTop, s};
  endfunction

  logic [MAG_W-1:0]  oldMagQ, newMagQ;
  logic              preCarryQ, postCarryQ;
  logic [ACC_W-1:0]  vnAccQ;
  logic [MSG_W-1:0]  vnHoldQ;
  logic              holdEnQ, holdValidQ;
  logic              satPosQ, satNegQ;

  logic [MSG_W-1:0]  oldExt, newExt, preSatVal;
  logic [PAIR_W-1:0] oldSlice, newSlice, vnSlice, preOp, postOp, outNext;
  logic              preInvE, postInvE, preCin, postCin;
  logic [PAIR_W+1:0] preR, postR;
  logic              preOvf, edp, edn;

  always_comb begin
    oldExt   = MSG_W'(stb.s0 ? oldMag : oldMagQ);
    newExt   = MSG_W'(stb.s0 ? newMag : newMagQ);
    oldSlice = oldExt[int'(stb.idx)*PAIR_W +: PAIR_W];
    newSlice = newExt[int'(stb.idx)*PAIR_W +: PAIR_W];
    vnSlice  = vnHoldQ[int'(stb.idx)*PAIR_W +: PAIR_W];

    // pre-update: APP minus old check message
    preInvE = stb.preInv & stb.en;
    preOp   = (stb.en ? oldSlice : '0) ^ {PAIR_W{preInvE}};
    preCin  = stb.s0 ? preInvE : preCarryQ;
    preR    = ripPair(appPair, preOp, preCin);
    preOvf  = preR[PAIR_W] ^ preR[PAIR_W+1];
    preSatVal = appPair[PAIR_W-1] ? {1'b1, {(MSG_W-1){1'b0}}}
                                  : {1'b0, {(MSG_W-1){1'b1}}};

    // post-update: held VN plus new check message
    postInvE = stb.postInv & holdEnQ;
    postOp   = (holdEnQ ? newSlice : '0) ^ {PAIR_W{postInvE}};
    postCin  = stb.s0 ? postInvE : postCarryQ;
    postR    = ripPair(vnSlice, postOp, postCin);

    // early overflow prediction in state 1 (magnitude fits below the top pair)
    edp = stb.s1 & ~vnHoldQ[MSG_W-1] &  vnHoldQ[MSG_W-2] & ~postInvE &  postR[PAIR_W+1];
    edn = stb.s1 &  vnHoldQ[MSG_W-1] & ~vnHoldQ[MSG_W-2] &  postInvE & ~postR[PAIR_W+1];

    outNext = postR[PAIR_W-1:0];
    if (stb.s1) begin
      if (edp)      outNext = '1;
      else if (edn) outNext = '0;
    end else if (stb.s2) begin
      if (satPosQ)      outNext = {1'b0, {(PAIR_W-1){1'b1}}};
      else if (satNegQ) outNext = {1'b1, {(PAIR_W-1){1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oldMagQ    <= '0;
      newMagQ    <= '0;
      preCarryQ  <= 1'b0;
      postCarryQ <= 1'b0;
      vnAccQ     <= '0;
      vnHoldQ    <= '0;
      holdEnQ    <= 1'b0;
      holdValidQ <= 1'b0;
      satPosQ    <= 1'b0;
      satNegQ    <= 1'b0;
      outPair    <= '0;
      outValid   <= 1'b0;
      outIdx     <= '0;
    end else if (stb.vld) begin
      if (stb.s0) begin
        oldMagQ <= oldMag;
        newMagQ <= newMag;
        satPosQ <= 1'b0;
        satNegQ <= 1'b0;
      end
      if (stb.s1) begin
        satPosQ <= edp;
        satNegQ <= edn;
      end
      preCarryQ  <= preR[PAIR_W+1];
      postCarryQ <= postR[PAIR_W+1];
      if (stb.s2) begin
        vnHoldQ    <= preOvf ? preSatVal : {preR[PAIR_W-1:0], vnAccQ};
        holdEnQ    <= stb.en;
        holdValidQ <= 1'b1;
      end else begin
        vnAccQ[int'(stb.idx)*PAIR_W +: PAIR_W] <= preR[PAIR_W-1:0];
      end
      outPair  <= outNext;
      outValid <= holdValidQ;
      outIdx   <= stb.idx;
    end else begin
      outValid <= 1'b0;
    end
  end

  AST_SAT_POS_TAIL: assert property (@(posedge clk) disable iff (!rstN)
    (stb.vld && stb.s2 && satPosQ) |=> (outPair == {1'b0, {(PAIR_W-1){1'b1}}})); // R4
  AST_SAT_NEG_TAIL: assert property (@(posedge clk) disable iff (!rstN)
    (stb.vld && stb.s2 && satNegQ) |=> (outPair == {1'b1, {(PAIR_W-1){1'b0}}})); // R5
  AST_SAT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(satPosQ && satNegQ)); // R4
  AST_BYPASS_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.vld && stb.s2 && holdValidQ && !holdEnQ) |=>
      (outPair == $past(vnHoldQ[MSG_W-1 -: PAIR_W]))); // R6
  AST_NO_EARLY_OUT: assert property (@(posedge clk) disable iff (!rstN)
    !holdValidQ |=> !outValid); // R7
endmodule

// File: rtl/app_serial_lane.sv
`timescale 1ns/1ps
module app_serial_lane
  import lane_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  stateIdx,
  input  logic              inValid,
  input  logic              updEn,
  input  logic [PAIR_W-1:0] appPair,
  input  logic              oldSign,
  input  logic [MAG_W-1:0]  oldMag,
  input  logic              newSign,
  input  logic [MAG_W-1:0]  newMag,
  output logic [PAIR_W-1:0] outPair,
  output logic              outValid,
  output logic [IDX_W-1:0]  outIdx
);
  laneStrobe_t stb;

  lane_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .stateIdx(stateIdx),
    .inValid (inValid),
    .updEn   (updEn),
    .oldSign (oldSign),
    .newSign (newSign),
    .stb     (stb)
  );

  lane_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .appPair (appPair),
    .oldMag  (oldMag),
    .newMag  (newMag),
    .outPair (outPair),
    .outValid(outValid),
    .outIdx  (outIdx)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!outValid || !rstN)); // R8
endmodule

// File: tb/sim_app_serial_lane.sv
`timescale 1ns/1ps
module sim_app_serial_lane;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rstN;
  logic [1:0] stateIdx;
  logic       inValid, updEn, oldSign, newSign;
  logic [1:0] appPair;
  logic [3:0] oldMag, newMag;
  logic [1:0] outPair;
  logic       outValid;
  logic [1:0] outIdx;

  app_serial_lane u0 (
    .clk(clk), .rstN(rstN), .stateIdx(stateIdx), .inValid(inValid),
    .updEn(updEn), .appPair(appPair), .oldSign(oldSign), .oldMag(oldMag),
    .newSign(newSign), .newMag(newMag), .outPair(outPair),
    .outValid(outValid), .outIdx(outIdx)
  );

  int errs = 0;
  int checks = 0;
  bit done = 0;

  int pendSt = -1;
  logic [5:0] gotV = '0;
  int  holdVn = 0;
  bit  holdEn = 0, holdHas = 0, holdWig = 0, holdPreSat = 0;
  int  curPre = 0, curNc = 0;
  bit  curEn = 0, curWig = 0, curPreSat = 0;

  function automatic int sgnMag(input bit s, input int m);
    return s ? -m : m;
  endfunction

  function automatic int clampMsg(input int v);
    if (v > 31) return 31;
    if (v < -32) return -32;
    return v;
  endfunction

  function automatic int postOf(input int vn, input int nc, input bit en);
    int s;
    if (!en) return vn;
    s = vn + nc;
    if (s > 31) return 28 + (s & 3);
    if (s < -32) return -32 + (s & 3);
    return s;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sampleOut();
    int expV, sum;
    string tag;
    if (pendSt < 0) begin
      chk(outValid == 1'b0, "R7", int'(outValid), 0);
      return;
    end
    if (!holdHas) begin
      chk(outValid == 1'b0, "R7", int'(outValid), 0);
    end else begin
      chk(outValid == 1'b1, "R7", int'(outValid), 1);
      chk(int'(outIdx) == pendSt, "R1", int'(outIdx), pendSt);
      gotV[pendSt*2 +: 2] = outPair;
      if (pendSt == 2) begin
        expV = postOf(holdVn, curNc, holdEn);
        sum  = holdVn + curNc;
        if (!holdEn)         tag = "R6";
        else if (sum > 31)   tag = "R4";
        else if (sum < -32)  tag = "R5";
        else if (holdWig)    tag = "R9";
        else if (holdPreSat) tag = "R3";
        else                 tag = "R2";
        chk(int'($signed(gotV)) == expV, tag, int'($signed(gotV)), expV);
      end
    end
    if (pendSt == 2) begin
      holdVn = curPre; holdEn = curEn; holdHas = 1;
      holdWig = curWig; holdPreSat = curPreSat;
    end
  endtask

  task automatic driveSlot(input int app, input bit oS, input int oM,
                           input bit nS, input int nM, input bit en, input bit wig);
    logic [5:0] a6;
    int d;
    a6 = app[5:0];
    d  = app - sgnMag(oS, oM);
    for (int st = 0; st < 3; st++) begin
      @(negedge clk);
      sampleOut();
      if (st == 0) begin
        curPre    = en ? clampMsg(d) : app;
        curPreSat = en && (d > 31 || d < -32);
        curEn     = en;
        curNc     = sgnMag(nS, nM);
        curWig    = wig;
      end
      stateIdx = 2'(st);
      inValid  = 1'b1;
      appPair  = a6[st*2 +: 2];
      if (st > 0 && wig) begin
        updEn = ~en; oldSign = ~oS; oldMag = 4'(15 - oM);
        newSign = ~nS; newMag = 4'(15 - nM);
      end else begin
        updEn = en; oldSign = oS; oldMag = 4'(oM);
        newSign = nS; newMag = 4'(nM);
      end
      pendSt = st;
    end
  endtask

  task automatic idleCycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sampleOut();
      inValid = 1'b0;
      stateIdx = 2'd0;
      pendSt = -1;
    end
  endtask

  initial begin
    rstN = 1'b0; stateIdx = '0; inValid = 1'b0; updEn = 1'b0; appPair = '0;
    oldSign = 1'b0; oldMag = '0; newSign = 1'b0; newMag = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(outValid == 1'b0, "R8", int'(outValid), 0);
    chk(outPair == 2'b00, "R8", int'(outPair), 0);
    rstN = 1'b1;
    idleCycles(2);
    for (int a = -32; a < 32; a++) begin
      for (int c = 0; c < 32; c++) begin
        int k;
        k = (a + 32) * 32 + c;
        if (k == 1000) idleCycles(5); // R7: held message survives idle gap
        driveSlot(a, c[4], c & 15, bit'((k / 5) % 2), (k * 11) % 16,
                  (k % 7) != 3, (k % 4) == 2);
      end
    end
    idleCycles(3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule